// File: doc/BRIEF.md
# Dual-Channel Odd/Even Pixel Merger

This block rebuilds one ordered line of pixels from two half-rate sample streams. A line sensor row is read out through two registers: one carries the even-numbered elements of the line and the other the odd-numbered elements. Each channel delivers one digitized sample per reset-clock period, qualified by its own valid strobe. The merger takes each even/odd pair and emits the even sample first, then the odd sample. The result is one stream at twice the per-channel rate.

Every emitted element is tagged with a 2-bit region code taken from its position in the line. Each line holds 5134 elements. The first 26 are vacant transfer elements. The next 96 are optical black, followed by 6 invalid elements, then 5000 active pixels, and finally 6 more invalid elements. Start-of-line and end-of-line markers frame the line.

For a downstream dark clamp, the block also produces a per-line mean of the optical-black samples. A valid strobe that arrives without its partner is reported on an error flag and the pair is dropped. A pair that arrives too soon after the previous one is treated the same way.

Top module: `pixel_pair_merger`

## Requirements
- R1: When both valid strobes are high in a cycle with no odd sample pending, `pixValid` is high for the next two cycles: `pixData` carries the even sample in the first and the odd sample in the second.
- R2: Each emitted element has an index in the line. The index starts at 0 after reset, advances by one per emitted element, and wraps from 5133 to 0. `pixRegion` is 2'b00 for index 0..25, 2'b01 for 26..121, 2'b10 for 122..127, 2'b11 for 128..5127 and 2'b10 for 5128..5133.
- R3: `pixSol` is high exactly on the element with index 0.
- R4: `pixEol` is high exactly on the element with index 5133; the element after it has index 0.
- R5: A cycle with exactly one valid strobe high raises `pairErr` for one cycle starting the next cycle. Nothing is emitted for it and the element index does not advance.
- R6: A pair arriving in the cycle right after an accepted pair raises `pairErr` the next cycle and is dropped. The odd sample of the accepted pair is still emitted.
- R7: `obAvg` is the truncated mean of the last 64 optical-black samples of the line (indices 58..121), i.e. their sum shifted right by 6. `obAvgValid` is high for exactly one cycle, the cycle after index 121 is presented, and `obAvg` holds its value until the next line.
- R8: After reset `pixValid`, `pixSol`, `pixEol`, `pairErr` and `obAvgValid` are low. `pixValid` is high only in the two cycles that follow an accepted pair.
- R9: Idle cycles between pairs, of any length, do not change the emitted sequence of data, regions or markers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the merged element rate |
| rstN | input | 1 | Active-low synchronous reset |
| evenValid | input | 1 | Even-channel sample strobe |
| evenData | input | 12 | Even-channel sample |
| oddValid | input | 1 | Odd-channel sample strobe |
| oddData | input | 12 | Odd-channel sample |
| pixValid | output | 1 | Merged element valid |
| pixData | output | 12 | Merged element sample |
| pixRegion | output | 2 | Region code of the element |
| pixSol | output | 1 | First element of the line |
| pixEol | output | 1 | Last element of the line |
| pairErr | output | 1 | Unpaired or too-early strobe seen, pair dropped |
| obAvg | output | 12 | Mean of the optical-black window |
| obAvgValid | output | 1 | One-cycle strobe for a new `obAvg` |

## Verification
Three full lines are streamed with sample values that depend on both index and line number. A swap of even and odd, an off-by-one region boundary or a missed wrap therefore shows up as a data or tag mismatch. Pairs come at the minimum two-cycle spacing and also with longer idle gaps, so any dependence on spacing is separated from the merge ordering itself. One line carries lone even strobes, lone odd strobes and back-to-back pairs, so that dropping a pair can be told apart from a counter that advances anyway. Another line holds every optical-black sample at full scale, which shows whether the accumulator is wide enough and whether the window is placed correctly.

// File: rtl/pxm_pkg.sv
package pxm_pkg;

  typedef enum logic [1:0] {
    REG_VACANT  = 2'b00,
    REG_DARK    = 2'b01,
    REG_INVALID = 2'b10,
    REG_ACTIVE  = 2'b11
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPair;
    logic emitOdd;
    logic darkAdd;
    logic darkDone;
  } dpCtrl_t;

endpackage

// File: rtl/pxm_ctrl.sv
module pxm_ctrl
  import pxm_pkg::*;
#(
  parameter int VACANT_CNT   = 26,
  parameter int DARK_CNT     = 96,
  parameter int LEAD_INV_CNT = 6,
  parameter int ACTIVE_CNT   = 5000,
  parameter int TAIL_INV_CNT = 6,
  parameter int DARK_LOG     = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    evenValid,
  input  logic    oddValid,
  output dpCtrl_t ctrl,
  output logic    pixValid,
  output region_e pixRegion,
  output logic    pixSol,
  output logic    pixEol,
  output logic    pairErr
);

  localparam int LINE_LEN = VACANT_CNT + DARK_CNT + LEAD_INV_CNT + ACTIVE_CNT + TAIL_INV_CNT;
  localparam int IDX_W    = $clog2(LINE_LEN);
  localparam int DARK_WIN = 1 << DARK_LOG;

  localparam logic [IDX_W-1:0] LAST_IDX     = IDX_W'(LINE_LEN - 1);
  localparam logic [IDX_W-1:0] DARK_LO      = IDX_W'(VACANT_CNT);
  localparam logic [IDX_W-1:0] DARK_HI      = IDX_W'(VACANT_CNT + DARK_CNT - 1);
  localparam logic [IDX_W-1:0] DARK_WIN_LO  = IDX_W'(VACANT_CNT + DARK_CNT - DARK_WIN);
  localparam logic [IDX_W-1:0] ACTIVE_LO    = IDX_W'(VACANT_CNT + DARK_CNT + LEAD_INV_CNT);
  localparam logic [IDX_W-1:0] ACTIVE_HI    = IDX_W'(VACANT_CNT + DARK_CNT + LEAD_INV_CNT + ACTIVE_CNT - 1);

  logic             oddPending;
  logic             bothValid;
  logic             emit;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] curIdx;

  function automatic region_e regionOf(input logic [IDX_W-1:0] idx);
    if (idx < DARK_LO)                           return REG_VACANT;
    else if (idx <= DARK_HI)                     return REG_DARK;
    else if (idx >= ACTIVE_LO && idx <= ACTIVE_HI) return REG_ACTIVE;
    else                                          return REG_INVALID;
  endfunction

  always_comb begin
    bothValid     = evenValid && oddValid;
    ctrl.loadPair = bothValid && !oddPending;
    ctrl.emitOdd  = oddPending;
    emit          = ctrl.loadPair || oddPending;
    ctrl.darkAdd  = pixValid && (curIdx >= DARK_WIN_LO) && (curIdx <= DARK_HI);
    ctrl.darkDone = pixValid && (curIdx == DARK_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddPending <= 1'b0;
      pixValid   <= 1'b0;
      pixRegion  <= REG_VACANT;
      pixSol     <= 1'b0;
      pixEol     <= 1'b0;
      pairErr    <= 1'b0;
      nextIdx    <= '0;
      curIdx     <= '0;
    end else begin
      oddPending <= ctrl.loadPair;
      pixValid   <= emit;
      pairErr    <= (evenValid ^ oddValid) || (bothValid && oddPending);
      if (emit) begin
        curIdx    <= nextIdx;
        nextIdx   <= (nextIdx == LAST_IDX) ? '0 : nextIdx + 1'b1;
        pixRegion <= regionOf(nextIdx);
        pixSol    <= (nextIdx == '0);
        pixEol    <= (nextIdx == LAST_IDX);
      end else begin
        pixSol    <= 1'b0;
        pixEol    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pxm_datapath.sv
module pxm_datapath
  import pxm_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int DARK_LOG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] evenData,
  input  logic [DATA_W-1:0] oddData,
  output logic [DATA_W-1:0] pixData,
  output logic [DATA_W-1:0] obAvg,
  output logic              obAvgValid
);

  localparam int ACC_W = DATA_W + DARK_LOG;

  logic [DATA_W-1:0] oddHold;
  logic [ACC_W-1:0]  darkAcc;
  logic [ACC_W-1:0]  darkSum;

  assign darkSum = darkAcc + ACC_W'(pixData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixData <= '0;
      oddHold <= '0;
    end else if (ctrl.loadPair) begin
      pixData <= evenData;
      oddHold <= oddData;
    end else if (ctrl.emitOdd) begin
      pixData <= oddHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      darkAcc    <= '0;
      obAvg      <= '0;
      obAvgValid <= 1'b0;
    end else begin
      obAvgValid <= ctrl.darkDone;
      if (ctrl.darkDone) begin
        obAvg   <= DATA_W'(darkSum >> DARK_LOG);
        darkAcc <= '0;
      end else if (ctrl.darkAdd) begin
        darkAcc <= darkSum;
      end
    end
  end

endmodule

// File: rtl/pixel_pair_merger.sv
module pixel_pair_merger
  import pxm_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int VACANT_CNT   = 26,
  parameter int DARK_CNT     = 96,
  parameter int LEAD_INV_CNT = 6,
  parameter int ACTIVE_CNT   = 5000,
  parameter int TAIL_INV_CNT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evenValid,
  input  logic [DATA_W-1:0] evenData,
  input  logic              oddValid,
  input  logic [DATA_W-1:0] oddData,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixData,
  output logic [1:0]        pixRegion,
  output logic              pixSol,
  output logic              pixEol,
  output logic              pairErr,
  output logic [DATA_W-1:0] obAvg,
  output logic              obAvgValid
);

  // largest power of two not above the dark count
  localparam int DARK_LOG = $clog2(DARK_CNT + 1) - 1;

  dpCtrl_t ctrl;
  region_e regionTag;

  pxm_ctrl #(
    .VACANT_CNT  (VACANT_CNT),
    .DARK_CNT    (DARK_CNT),
    .LEAD_INV_CNT(LEAD_INV_CNT),
    .ACTIVE_CNT  (ACTIVE_CNT),
    .TAIL_INV_CNT(TAIL_INV_CNT),
    .DARK_LOG    (DARK_LOG)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evenValid(evenValid),
    .oddValid (oddValid),
    .ctrl     (ctrl),
    .pixValid (pixValid),
    .pixRegion(regionTag),
    .pixSol   (pixSol),
    .pixEol   (pixEol),
    .pairErr  (pairErr)
  );

  pxm_datapath #(
    .DATA_W  (DATA_W),
    .DARK_LOG(DARK_LOG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .evenData  (evenData),
    .oddData   (oddData),
    .pixData   (pixData),
    .obAvg     (obAvg),
    .obAvgValid(obAvgValid)
  );

  assign pixRegion = regionTag;

endmodule

// File: rtl/pxm_checker.sv
module pxm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       evenValid,
  input logic       oddValid,
  input logic       pixValid,
  input logic [1:0] pixRegion,
  input logic       pixSol,
  input logic       pixEol,
  input logic       pairErr,
  input logic       obAvgValid
);

  // R1
  pair_emits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid && oddValid) |=> pixValid);

  // R3
  sol_vacant_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixSol |-> (pixValid && pixRegion == 2'b00 && !pixEol));

  // R4
  eol_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixEol |-> (pixValid && pixRegion == 2'b10));

  // R5
  lone_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evenValid ^ oddValid) |=> pairErr);

  // R7
  avg_after_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    obAvgValid |-> ($past(pixValid) && $past(pixRegion) == 2'b01));

  // R7
  avg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    obAvgValid |=> !obAvgValid);

endmodule

bind pixel_pair_merger pxm_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evenValid (evenValid),
  .oddValid  (oddValid),
  .pixValid  (pixValid),
  .pixRegion (pixRegion),
  .pixSol    (pixSol),
  .pixEol    (pixEol),
  .pairErr   (pairErr),
  .obAvgValid(obAvgValid)
);

// File: tb/pixel_pair_merger_bench.sv
module pixel_pair_merger_bench;

  localparam int LAST = 5133;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evenValid = 1'b0, oddValid = 1'b0;
  logic [11:0] evenData = '0, oddData = '0;
  logic        pixValid, pixSol, pixEol, pairErr, obAvgValid;
  logic [11:0] pixData, obAvg;
  logic [1:0]  pixRegion;

  always #2 clk = ~clk;

  pixel_pair_merger u_pixel_pair_merger (
    .clk(clk), .rstN(rstN),
    .evenValid(evenValid), .evenData(evenData),
    .oddValid(oddValid), .oddData(oddData),
    .pixValid(pixValid), .pixData(pixData), .pixRegion(pixRegion),
    .pixSol(pixSol), .pixEol(pixEol), .pairErr(pairErr),
    .obAvg(obAvg), .obAvgValid(obAvgValid)
  );

  typedef struct packed {
    logic [11:0] d;
    logic [1:0]  r;
    logic        s;
    logic        e;
  } item_t;

  item_t expQ[$];
  int    avgQ[$];
  int    checks = 0, failures = 0;
  int    mIdx = 0, darkSum = 0;
  int    errSeen = 0, errExp = 0;
  logic  prevAvgValid = 1'b0;
  bit    done = 1'b0;

  function automatic logic [1:0] regionOf(input int idx);
    if (idx < 26)        return 2'b00;
    else if (idx < 122)  return 2'b01;
    else if (idx < 128)  return 2'b10;
    else if (idx < 5128) return 2'b11;
    else                 return 2'b10;
  endfunction

  function automatic logic [11:0] pixVal(input int line, input int idx);
    if (line == 2 && idx >= 26 && idx < 122) return 12'hFFF;
    return 12'((idx * 37 + line * 101 + (idx >> 3)) % 4096);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushElem(input logic [11:0] v);
    item_t it;
    it.d = v;
    it.r = regionOf(mIdx);
    it.s = (mIdx == 0);
    it.e = (mIdx == LAST);
    expQ.push_back(it);
    if (mIdx >= 58 && mIdx <= 121) darkSum += int'(v);
    if (mIdx == 121) begin
      avgQ.push_back(darkSum >> 6);
      darkSum = 0;
    end
    mIdx = (mIdx == LAST) ? 0 : mIdx + 1;
  endtask

  task automatic sendPair(input logic [11:0] e, input logic [11:0] o, input int gap);
    pushElem(e);
    pushElem(o);
    @(negedge clk);
    evenValid = 1'b1; oddValid = 1'b1; evenData = e; oddData = o;
    @(negedge clk);
    evenValid = 1'b0; oddValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // R5: lone strobe on one channel
  task automatic sendLone(input bit useEven, input logic [11:0] v);
    @(negedge clk);
    evenValid = useEven; oddValid = !useEven; evenData = v; oddData = v;
    @(negedge clk);
    evenValid = 1'b0; oddValid = 1'b0;
    check(pairErr == 1'b1, "R5 pairErr after lone strobe", pairErr, 1);
    errExp++;
  endtask

  // R6: second pair one cycle after the first
  task automatic sendBurst(input logic [11:0] e, input logic [11:0] o);
    pushElem(e);
    pushElem(o);
    @(negedge clk);
    evenValid = 1'b1; oddValid = 1'b1; evenData = e; oddData = o;
    @(negedge clk);
    evenData = ~e; oddData = ~o;
    @(negedge clk);
    evenValid = 1'b0; oddValid = 1'b0;
    check(pairErr == 1'b1, "R6 pairErr after early pair", pairErr, 1);
    errExp++;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: scoreboard pops
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (pixValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected pixValid", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(pixData == it.d, "R1 R9 pixData", int'(pixData), int'(it.d));
          check(pixRegion == it.r, "R2 pixRegion", int'(pixRegion), int'(it.r));
          check(pixSol == it.s, "R3 pixSol", int'(pixSol), int'(it.s));
          check(pixEol == it.e, "R4 pixEol", int'(pixEol), int'(it.e));
        end
      end else begin
        if (pixSol || pixEol) check(1'b0, "R3 R4 marker without pixValid", 1, 0);
      end
      if (obAvgValid) begin
        check(!prevAvgValid, "R7 obAvgValid longer than one cycle", 1, 0);
        if (avgQ.size() == 0) begin
          check(1'b0, "R7 unexpected obAvgValid", 1, 0);
        end else begin
          int ea;
          ea = avgQ.pop_front();
          check(int'(obAvg) == ea, "R7 obAvg", int'(obAvg), ea);
        end
      end
      if (pairErr) errSeen++;
      prevAvgValid <= obAvgValid;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(pixValid == 1'b0, "R8 reset pixValid", pixValid, 0);
    check(pixSol == 1'b0 && pixEol == 1'b0, "R8 reset markers", pixSol | pixEol, 0);
    check(pairErr == 1'b0, "R8 reset pairErr", pairErr, 0);
    check(obAvgValid == 1'b0, "R8 reset obAvgValid", obAvgValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(pixValid == 1'b0, "R8 idle after reset", pixValid, 0);

    for (int line = 0; line < 3; line++) begin
      for (int k = 0; k < 2567; k++) begin
        logic [11:0] e, o;
        e = pixVal(line, 2 * k);
        o = pixVal(line, 2 * k + 1);
        if (line == 1 && (k % 500) == 250) sendLone(1'b1, 12'h5A5);
        if (line == 1 && (k % 700) == 100) sendLone(1'b0, 12'hA5A);
        if (line == 1 && (k % 600) == 300) begin
          sendBurst(e, o);
        end else begin
          // R9: mixed spacing
          sendPair(e, o, ((k % 5) == 3) ? 3 : ((line == 2 && (k % 11) == 0) ? 7 : 0));
        end
      end
    end

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R1 all elements emitted", expQ.size(), 0);
    check(avgQ.size() == 0, "R7 all dark averages emitted", avgQ.size(), 0);
    check(errSeen == errExp, "R5 R6 pairErr pulse count", errSeen, errExp);
    finishRun();
  end

endmodule